// File: doc/BRIEF.md
# Multi-Type Delay and Flasher Timer

This block is one timer element of a scan-based control engine. A 3-bit type code picks one of six timing behaviours: a plain on-delay, a retentive on-delay that adds up separate enable intervals, an off-delay that holds its status while enabled, a trailing-edge pulse, a flasher gated by the enable, and a flasher that latches on and runs until cleared. All behaviours share one accumulator. The accumulator moves only in cycles where the time-base `tick` input is high, so one count equals one time-base period.

The surrounding logic drives the rung condition on `enable`, a synchronous `clear`, and the preset in ticks. It reads back the accumulated count and the status bit. The type code is expected to stay steady while a timing sequence runs. Every output is registered and follows its inputs at the next clock edge.

The controller uses seven named states. IDLE means status off and nothing running. TIMING means counting toward the preset with status off. PAUSED means a retentive partial count is held while the enable is low. ACTIVE means status on and steady. HOLDOFF means status on while counting toward switch-off. FLASH_LO and FLASH_HI are the two flasher phases. The status bit is on in ACTIVE, HOLDOFF and FLASH_HI.

The transitions are as follows. A clear sends every state to IDLE. The on-delay types go TIMING→ACTIVE when the preset is reached, and a retentive count goes TIMING→PAUSED when the enable drops. The off-delay goes ACTIVE→HOLDOFF→IDLE. The pulse goes IDLE→HOLDOFF on a falling enable, then HOLDOFF→IDLE on timeout or a rising enable. The flashers alternate FLASH_LO↔FLASH_HI.

Top module: `multi_mode_timer`

## Requirements
- R1: After reset, and at the edge following any cycle with `clear` high, `acc_value` is 0 and `status` is 0, whatever the type code and `enable` are.
- R2: For type codes 1 to 4, the accumulator grows by one only at an edge where `tick` was high, and it never exceeds `preset`. Once it reaches `preset` it stays there.
- R3: Type code 1 (on-delay): while `enable` is high, `status` rises at the same edge where `acc_value` reaches `preset`. A cycle with `enable` low returns both outputs to 0 at the next edge.
- R4: Type code 2 (retentive on-delay): the count adds up over separate enable-high intervals. The count is held while `enable` is low. Once `status` is on, it stays on, even with `enable` low, until a clear.
- R5: Type code 3 (off-delay): while `enable` is high, `status` is 1 and `acc_value` is 0. After `enable` falls, ticks are counted, and `status` drops at the edge where the count reaches `preset`. If `enable` returns before then, the count restarts from 0 with `status` still 1. After reset or clear, with `enable` low, nothing is timed.
- R6: Type code 4 (trailing pulse): the edge after a high-to-low change of `enable` gives `status` 1 and `acc_value` 0. Ticks are then counted and `status` drops when the count reaches `preset`. A high `enable` before timeout gives `status` 0 and `acc_value` 0.
- R7: Type code 5 (gated flasher): while `enable` is high, `status` starts at 0 and inverts each time `preset` ticks have been counted. The count wraps to 0 at each inversion. `enable` low gives `status` 0 and `acc_value` 0 at the next edge.
- R8: Type code 6 (latched flasher): a single-cycle `enable` pulse starts the same flashing as R7. The flashing continues with `enable` low and stops only on a clear.
- R9: Type codes 0 and 7 are inactive: `acc_value` and `status` are 0 at every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base pulse, one clock wide |
| enable | input | 1 | Rung condition |
| clear | input | 1 | Synchronous reset of count and status |
| mode | input | 3 | Timer type code (0..7) |
| preset | input | CNT_W | Preset in ticks |
| acc_value | output | CNT_W | Accumulated tick count |
| status | output | 1 | Timer status bit |

## Verification
Each result is due exactly one clock edge after the inputs that cause it. This covers a count step on a tick, a status change at the preset, the pulse start after a falling enable, a flasher inversion, and the effect of a clear. The bench changes inputs on the falling clock edge and reads the outputs on the next falling edge, so every sample sees the effect of exactly one rising edge. Sequences are scripted cycle by cycle with small presets. Each expected count and status value is written down from the requirements before the step that should produce it.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [2:0] {
        TM_NONE        = 3'd0,
        TM_ON_DELAY    = 3'd1,
        TM_ON_RETAIN   = 3'd2,
        TM_OFF_HOLD    = 3'd3,
        TM_OFF_PULSE   = 3'd4,
        TM_FLASH_GATED = 3'd5,
        TM_FLASH_LATCH = 3'd6,
        TM_SPARE       = 3'd7
    } tmode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TIMING,
        ST_PAUSED,
        ST_ACTIVE,
        ST_HOLDOFF,
        ST_FLASH_LO,
        ST_FLASH_HI
    } tstate_t;

endpackage

// File: rtl/timer_edge_detect.sv
module timer_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign fall = level_q & ~level;
endmodule

// File: rtl/timer_step.sv
module timer_step #(
    parameter int CNT_W = 16
) (
    input  logic             tick,
    input  logic [CNT_W-1:0] acc,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] sat_next,
    output logic             sat_done,
    output logic [CNT_W-1:0] wrap_next,
    output logic             wrap_done
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] inc_ext;

    always_comb begin
        inc_ext = {1'b0, acc} + {{CNT_W{1'b0}}, 1'b1};

        // saturating advance for the delay types
        if (tick && (acc < preset)) sat_next = inc_ext[CNT_W-1:0];
        else                        sat_next = acc;
        sat_done = (sat_next >= preset);

        // wrapping advance for the flasher types
        wrap_done = tick && (inc_ext >= {1'b0, preset});
        if (!tick)          wrap_next = acc;
        else if (wrap_done) wrap_next = '0;
        else                wrap_next = inc_ext[CNT_W-1:0];
    end
endmodule

// File: rtl/timer_fsm.sv
module timer_fsm
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clear,
    input  logic             fall,
    input  logic [2:0]       mode,
    input  logic [CNT_W-1:0] acc,
    input  logic [CNT_W-1:0] sat_next,
    input  logic             sat_done,
    input  logic [CNT_W-1:0] wrap_next,
    input  logic             wrap_done,
    output logic [CNT_W-1:0] acc_q,
    output logic             status
);
    tstate_t          state, state_n;
    logic [CNT_W-1:0] acc_n;
    tmode_t           mode_e;
    logic             flash_hi;
    logic             flashing;

    always_comb begin
        mode_e   = tmode_t'(mode);
        flash_hi = (state == ST_FLASH_HI);
        flashing = (state == ST_FLASH_LO) || (state == ST_FLASH_HI);
        state_n  = state;
        acc_n    = acc;
        if (clear) begin
            state_n = ST_IDLE;
            acc_n   = '0;
        end else begin
            unique case (mode_e)
                TM_ON_DELAY: begin
                    if (!enable) begin
                        state_n = ST_IDLE;
                        acc_n   = '0;
                    end else begin
                        acc_n   = sat_next;
                        state_n = sat_done ? ST_ACTIVE : ST_TIMING;
                    end
                end
                TM_ON_RETAIN: begin
                    if (enable) begin
                        acc_n   = sat_next;
                        state_n = sat_done ? ST_ACTIVE : ST_TIMING;
                    end else if (state == ST_ACTIVE) begin
                        state_n = ST_ACTIVE;
                    end else begin
                        state_n = (acc != '0) ? ST_PAUSED : ST_IDLE;
                    end
                end
                TM_OFF_HOLD: begin
                    if (enable) begin
                        state_n = ST_ACTIVE;
                        acc_n   = '0;
                    end else if (state == ST_ACTIVE || state == ST_HOLDOFF) begin
                        acc_n   = sat_next;
                        state_n = sat_done ? ST_IDLE : ST_HOLDOFF;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
                TM_OFF_PULSE: begin
                    if (enable) begin
                        state_n = ST_IDLE;
                        acc_n   = '0;
                    end else if (fall) begin
                        state_n = ST_HOLDOFF;
                        acc_n   = '0;
                    end else if (state == ST_HOLDOFF) begin
                        acc_n   = sat_next;
                        state_n = sat_done ? ST_IDLE : ST_HOLDOFF;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
                TM_FLASH_GATED: begin
                    if (!enable) begin
                        state_n = ST_IDLE;
                        acc_n   = '0;
                    end else begin
                        acc_n   = wrap_next;
                        state_n = (flash_hi ^ wrap_done) ? ST_FLASH_HI : ST_FLASH_LO;
                    end
                end
                TM_FLASH_LATCH: begin
                    if (enable || flashing) begin
                        acc_n   = wrap_next;
                        state_n = (flash_hi ^ wrap_done) ? ST_FLASH_HI : ST_FLASH_LO;
                    end else begin
                        state_n = ST_IDLE;
                        acc_n   = '0;
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    acc_n   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // output register and status decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_n;
    end

    assign status = (state == ST_ACTIVE) || (state == ST_HOLDOFF) ||
                    (state == ST_FLASH_HI);
endmodule

// File: rtl/multi_mode_timer.sv
module multi_mode_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic             clear,
    input  logic [2:0]       mode,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] acc_value,
    output logic             status
);
    logic             fall;
    logic [CNT_W-1:0] sat_next;
    logic             sat_done;
    logic [CNT_W-1:0] wrap_next;
    logic             wrap_done;

    timer_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (enable),
        .fall  (fall)
    );

    timer_step #(.CNT_W(CNT_W)) u_step (
        .tick      (tick),
        .acc       (acc_value),
        .preset    (preset),
        .sat_next  (sat_next),
        .sat_done  (sat_done),
        .wrap_next (wrap_next),
        .wrap_done (wrap_done)
    );

    timer_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .clear     (clear),
        .fall      (fall),
        .mode      (mode),
        .acc       (acc_value),
        .sat_next  (sat_next),
        .sat_done  (sat_done),
        .wrap_next (wrap_next),
        .wrap_done (wrap_done),
        .acc_q     (acc_value),
        .status    (status)
    );
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             enable,
    input logic             clear,
    input logic [2:0]       mode,
    input logic [CNT_W-1:0] preset,
    input logic [CNT_W-1:0] acc_value,
    input logic             status
);
    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_value == '0 && !status));

    assert_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode >= 3'd1 && mode <= 3'd4) |-> (acc_value <= preset));

    assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && enable && !clear && (mode == 3'd1 || mode == 3'd2)) |=> $stable(acc_value));

    assert_ondelay_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && !enable) |=> (acc_value == '0 && !status));

    assert_offhold_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && enable && !clear) |=> (status && acc_value == '0));

    assert_gated_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5 && !enable) |=> (acc_value == '0 && !status));

    assert_idle_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 || mode == 3'd7) |=> (acc_value == '0 && !status));
endmodule

bind multi_mode_timer timer_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/multi_mode_timer_test.sv
module multi_mode_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int WATCHDOG   = 5000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             enable = 1'b0;
    logic             clear = 1'b0;
    logic [2:0]       mode = 3'd0;
    logic [CNT_W-1:0] preset = '0;
    logic [CNT_W-1:0] acc_value;
    logic             status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    multi_mode_timer #(.CNT_W(CNT_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .enable    (enable),
        .clear     (clear),
        .mode      (mode),
        .preset    (preset),
        .acc_value (acc_value),
        .status    (status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // one cycle: drive inputs now (falling edge), return at next falling edge
    task automatic cyc(input bit e, input bit t, input bit c);
        enable = e;
        tick   = t;
        clear  = c;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input int ea, input bit es);
        checks++;
        if (acc_value !== ea[CNT_W-1:0] || status !== es) begin
            fails++;
            $display("FAIL %s: actual acc=%0d status=%0b expected acc=%0d status=%0b",
                     req, acc_value, status, ea, es);
        end
    endtask

    task automatic test_reset();
        expect_out("R1 reset state", 0, 0);
    endtask

    task automatic test_on_delay();
        mode = 3'd1; preset = 16'd3;
        cyc(1, 1, 1); expect_out("R1 clear beats enable", 0, 0);
        cyc(1, 0, 0); expect_out("R2 no tick no count", 0, 0);
        cyc(1, 1, 0); expect_out("R3 count 1", 1, 0);
        cyc(1, 1, 0); expect_out("R3 count 2", 2, 0);
        cyc(1, 0, 0); expect_out("R2 hold without tick", 2, 0);
        cyc(1, 1, 0); expect_out("R3 status at preset", 3, 1);
        cyc(1, 1, 0); expect_out("R2 saturate at preset", 3, 1);
        cyc(0, 0, 0); expect_out("R3 enable low clears", 0, 0);
    endtask

    task automatic test_retentive();
        mode = 3'd2; preset = 16'd3;
        cyc(0, 0, 1); expect_out("R1 clear", 0, 0);
        cyc(1, 1, 0); expect_out("R4 count 1", 1, 0);
        cyc(1, 1, 0); expect_out("R4 count 2", 2, 0);
        cyc(0, 1, 0); expect_out("R4 hold while low", 2, 0);
        cyc(0, 0, 0); expect_out("R4 still held", 2, 0);
        cyc(1, 1, 0); expect_out("R4 sum reaches preset", 3, 1);
        cyc(0, 1, 0); expect_out("R4 status kept when low", 3, 1);
        cyc(1, 1, 1); expect_out("R1 clear on retentive", 0, 0);
    endtask

    task automatic test_off_hold();
        mode = 3'd3; preset = 16'd3;
        cyc(0, 0, 1); expect_out("R1 clear", 0, 0);
        cyc(0, 1, 0); expect_out("R5 idle not timed", 0, 0);
        cyc(1, 1, 0); expect_out("R5 on while enabled", 0, 1);
        cyc(0, 1, 0); expect_out("R5 off count 1", 1, 1);
        cyc(0, 1, 0); expect_out("R5 off count 2", 2, 1);
        cyc(1, 0, 0); expect_out("R5 restart on return", 0, 1);
        cyc(0, 1, 0); expect_out("R5 recount 1", 1, 1);
        cyc(0, 1, 0); expect_out("R5 recount 2", 2, 1);
        cyc(0, 1, 0); expect_out("R5 drop at preset", 3, 0);
        cyc(0, 1, 0); expect_out("R2 stays at preset", 3, 0);
    endtask

    task automatic test_off_pulse();
        mode = 3'd4; preset = 16'd3;
        cyc(0, 0, 1); expect_out("R1 clear", 0, 0);
        cyc(1, 1, 0); expect_out("R6 enabled no pulse", 0, 0);
        cyc(0, 0, 0); expect_out("R6 pulse on fall", 0, 1);
        cyc(0, 1, 0); expect_out("R6 pulse count 1", 1, 1);
        cyc(1, 0, 0); expect_out("R6 rise cancels", 0, 0);
        cyc(0, 0, 0); expect_out("R6 second fall", 0, 1);
        cyc(0, 1, 0); expect_out("R6 count 1", 1, 1);
        cyc(0, 1, 0); expect_out("R6 count 2", 2, 1);
        cyc(0, 1, 0); expect_out("R6 end at preset", 3, 0);
    endtask

    task automatic test_flash_gated();
        mode = 3'd5; preset = 16'd2;
        cyc(0, 0, 1); expect_out("R1 clear", 0, 0);
        cyc(1, 1, 0); expect_out("R7 count 1 low", 1, 0);
        cyc(1, 0, 0); expect_out("R7 hold no tick", 1, 0);
        cyc(1, 1, 0); expect_out("R7 first toggle high", 0, 1);
        cyc(1, 1, 0); expect_out("R7 count in high", 1, 1);
        cyc(1, 1, 0); expect_out("R7 toggle low", 0, 0);
        cyc(1, 1, 0); expect_out("R7 count in low", 1, 0);
        cyc(1, 1, 0); expect_out("R7 toggle high again", 0, 1);
        cyc(0, 1, 0); expect_out("R7 stop forces off", 0, 0);
    endtask

    task automatic test_flash_latched();
        mode = 3'd6; preset = 16'd2;
        cyc(0, 0, 1); expect_out("R1 clear", 0, 0);
        cyc(0, 1, 0); expect_out("R8 no start without enable", 0, 0);
        cyc(1, 1, 0); expect_out("R8 start pulse", 1, 0);
        cyc(0, 1, 0); expect_out("R8 runs with enable low", 0, 1);
        cyc(0, 1, 0); expect_out("R8 count high", 1, 1);
        cyc(0, 1, 0); expect_out("R8 toggle low", 0, 0);
        cyc(0, 1, 0); expect_out("R8 count low", 1, 0);
        cyc(0, 1, 0); expect_out("R8 toggle high", 0, 1);
        cyc(0, 1, 1); expect_out("R8 clear stops", 0, 0);
        cyc(0, 1, 0); expect_out("R8 stays stopped", 0, 0);
    endtask

    task automatic test_idle_codes();
        preset = 16'd1;
        mode = 3'd0;
        cyc(1, 1, 0); expect_out("R9 code 0", 0, 0);
        cyc(1, 1, 0); expect_out("R9 code 0 again", 0, 0);
        mode = 3'd7;
        cyc(1, 1, 0); expect_out("R9 code 7", 0, 0);
        cyc(0, 1, 0); expect_out("R9 code 7 low", 0, 0);
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_on_delay();
        test_retentive();
        test_off_hold();
        test_off_pulse();
        test_flash_gated();
        test_flash_latched();
        test_idle_codes();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule